// File: doc/BRIEF.md
# Dynamic and Single-Bit Shifter

This unit is the shift and rotate path of a 32-bit integer datapath. Each strobe carries a data operand, an amount operand, a four-bit operation code and the current carry/test flag (T). One clock later it returns the shifted word and the new T value.

Two operations are dynamic shifts. They take both their direction and their distance from a signed amount register. A non-negative amount shifts left. A negative amount shifts right by 32 minus its low five bits. A negative amount whose low five bits are all zero clears the word. The other fourteen operations cover:
- one-bit shifts and rotates, which pass the bit shifted out into T;
- two rotates that pass through T;
- fixed logical shifts by 2, 8 and 16, which leave T alone.

The result and T are registered, so a downstream stage sees them together with a one-cycle valid pulse.

Top module: `shift_rot_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `result` and `t_out` are all 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `t_out` keep their values through cycles that follow a cycle with `in_valid` low.
- R3: For op 0 (arithmetic dynamic) and op 1 (logical dynamic), when `amount_in[31]` is 0 the result is `data_in` shifted left by `amount_in[4:0]`, with zeros entering at bit 0. Bits 30..5 of the amount are ignored, and `t_out` equals `t_in`.
- R4: For ops 0 and 1, when `amount_in[31]` is 1 and `amount_in[4:0]` is non-zero, the result is `data_in` shifted right by 32 minus `amount_in[4:0]`. Op 0 fills the vacated bits with `data_in[31]`, op 1 fills them with zeros, and `t_out` equals `t_in`.
- R5: For ops 0 and 1, when `amount_in[31]` is 1 and `amount_in[4:0]` is 0, the result is 0 and `t_out` equals `t_in`.
- R6: Op 2 rotates left by one and sets T to the old bit 31. Op 3 rotates right by one and sets T to the old bit 0.
- R7: Op 4 shifts left by one with `t_in` entering bit 0 and the old bit 31 going to T. Op 5 shifts right by one with `t_in` entering bit 31 and the old bit 0 going to T.
- R8: Op 6 and op 15 shift left by one with a zero into bit 0 and the old bit 31 into T. Op 7 shifts right by one keeping bit 31. Op 8 shifts right by one with a zero into bit 31. Ops 7 and 8 put the old bit 0 into T.
- R9: The fixed logical shifts fill with zeros and leave `t_out` equal to `t_in`. Ops 9, 10 and 11 shift left by 2, 8 and 16. Ops 12, 13 and 14 shift right by 2, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code (see R3 to R9) |
| data_in | input | 32 | Operand to shift |
| amount_in | input | 32 | Signed shift amount for the dynamic ops |
| t_in | input | 1 | Current T flag |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered shifted word |
| t_out | output | 1 | Registered new T flag |

## Verification
The bench sweeps all 64 combinations of amount sign and low five bits over several data words, including all-ones and words with bit 31 set. The middle amount bits are randomized on every run.

Each of the following faults shows up in that sweep:
- A design that shifted right by the inverted low bits without the plus one would be off by one on every negative amount.
- A design that treated a negative amount with zero low bits as a shift by 32, or as no shift, would return a non-zero word there.
- A design that used the wrong fill would leak zeros into arithmetic results on negative data, or sign bits into logical results.

The single-bit ops are run with both T values on patterns whose end bits differ. This exposes a rotate that confuses its incoming bit with T, or a fixed shift that disturbs T.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [3:0] {
    OP_DYN_ARITH = 4'd0,
    OP_DYN_LOGIC = 4'd1,
    OP_ROT_L     = 4'd2,
    OP_ROT_R     = 4'd3,
    OP_ROTC_L    = 4'd4,
    OP_ROTC_R    = 4'd5,
    OP_SHA_L1    = 4'd6,
    OP_SHA_R1    = 4'd7,
    OP_SHL_R1    = 4'd8,
    OP_SHL_L2    = 4'd9,
    OP_SHL_L8    = 4'd10,
    OP_SHL_L16   = 4'd11,
    OP_SHL_R2    = 4'd12,
    OP_SHL_R8    = 4'd13,
    OP_SHL_R16   = 4'd14,
    OP_SHL_L1    = 4'd15
  } shop_e;

  function automatic logic op_is_dyn(input shop_e o);
    return (o == OP_DYN_ARITH) || (o == OP_DYN_LOGIC);
  endfunction

  function automatic logic op_is_fixed(input shop_e o);
    return (o >= OP_SHL_L2) && (o <= OP_SHL_R16);
  endfunction

endpackage

// File: rtl/shrot_dyn.sv
// Sign-directed barrel shifter: left by the low bits when positive,
// right by (W - low) when negative, zero when negative with low bits 0.
module shrot_dyn #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic          neg,
  input  logic [AW-1:0] low,
  input  logic          arith,
  output logic [W-1:0]  res
);

  logic [AW-1:0] rdist;
  logic          fill;
  logic [W-1:0]  lstg [AW+1];
  logic [W-1:0]  rstg [AW+1];

  assign rdist   = (~low) + AW'(1);
  assign fill    = arith & data[W-1];
  assign lstg[0] = data;
  assign rstg[0] = data;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign lstg[s+1] = low[s]   ? {lstg[s][W-1-SH:0], {SH{1'b0}}} : lstg[s];
    assign rstg[s+1] = rdist[s] ? {{SH{fill}}, rstg[s][W-1:SH]}    : rstg[s];
  end

  always_comb begin
    if (!neg)            res = lstg[AW];
    else if (low == '0)  res = '0;
    else                 res = rstg[AW];
  end

endmodule

// File: rtl/shrot_fix.sv
// One-bit shifts, rotates and fixed-distance shifts.
module shrot_fix
  import shrot_pkg::*;
#(
  parameter int W = 32
) (
  input  shop_e        op,
  input  logic [W-1:0] data,
  input  logic         t_in,
  output logic [W-1:0] res,
  output logic         t_new
);

  logic msb, lsb;
  assign msb = data[W-1];
  assign lsb = data[0];

  always_comb begin
    res   = data;
    t_new = t_in;
    unique case (op)
      OP_ROT_L:   begin res = {data[W-2:0], msb};         t_new = msb; end
      OP_ROT_R:   begin res = {lsb, data[W-1:1]};         t_new = lsb; end
      OP_ROTC_L:  begin res = {data[W-2:0], t_in};        t_new = msb; end
      OP_ROTC_R:  begin res = {t_in, data[W-1:1]};        t_new = lsb; end
      OP_SHA_L1,
      OP_SHL_L1:  begin res = {data[W-2:0], 1'b0};        t_new = msb; end
      OP_SHA_R1:  begin res = {msb, data[W-1:1]};         t_new = lsb; end
      OP_SHL_R1:  begin res = {1'b0, data[W-1:1]};        t_new = lsb; end
      OP_SHL_L2:  res = data << 2;
      OP_SHL_L8:  res = data << 8;
      OP_SHL_L16: res = data << 16;
      OP_SHL_R2:  res = data >> 2;
      OP_SHL_R8:  res = data >> 8;
      OP_SHL_R16: res = data >> 16;
      default: begin res = data; t_new = t_in; end
    endcase
  end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shrot_pkg::*;
#(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] amount_in,
  input  logic         t_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         t_out
);

  shop_e        op_e;
  logic [W-1:0] dyn_res, fix_res, nxt_res;
  logic         fix_t, nxt_t;

  assign op_e = shop_e'(op);

  shrot_dyn #(.W(W)) u_dyn (
    .data  (data_in),
    .neg   (amount_in[W-1]),
    .low   (amount_in[AW-1:0]),
    .arith (op_e == OP_DYN_ARITH),
    .res   (dyn_res)
  );

  shrot_fix #(.W(W)) u_fix (
    .op    (op_e),
    .data  (data_in),
    .t_in  (t_in),
    .res   (fix_res),
    .t_new (fix_t)
  );

  always_comb begin
    if (op_is_dyn(op_e)) begin
      nxt_res = dyn_res;
      nxt_t   = t_in;
    end else begin
      nxt_res = fix_res;
      nxt_t   = fix_t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      t_out     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        t_out  <= nxt_t;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(t_out)));
  a_r5_neg_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_dyn(op_e) && amount_in[W-1] && amount_in[AW-1:0] == '0)
      |=> (result == '0));
  a_r9_fixed_keep_t: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_fixed(op_e)) |=> (t_out == $past(t_in)));
  a_r6_rotl_t: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_ROT_L) |=> (t_out == $past(data_in[W-1])
                                        && result[0] == t_out));
  a_r7_rotcr_in: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_ROTC_R) |=> (result[W-1] == $past(t_in)));

endmodule

// File: tb/shift_rot_unit_test.sv
module shift_rot_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] data_in = '0;
  logic [31:0] amount_in = '0;
  logic        t_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        t_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  shift_rot_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .data_in(data_in), .amount_in(amount_in), .t_in(t_in),
    .out_valid(out_valid), .result(result), .t_out(t_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_dyn(input bit arith, input logic [31:0] d,
                                          input logic [31:0] a);
    int low = int'(a[4:0]);
    logic [63:0] wide;
    if (!a[31]) return d << low;
    if (low == 0) return 32'd0;
    wide = arith ? {{32{d[31]}}, d} : {32'd0, d};
    wide = wide >> (32 - low);
    return wide[31:0];
  endfunction

  function automatic logic [32:0] exp_fix(input int o, input logic [31:0] d, input logic t);
    logic [63:0] dd;
    dd = {d, d};
    case (o)
      2:  return {d[31], dd[62:31]};
      3:  return {d[0], dd[32:1]};
      4:  return {d[31], d[30:0], t};
      5:  return {d[0], t, d[31:1]};
      6, 15: return {d[31], d * 32'd2};
      7:  return {d[0], 32'($signed(d) / 2 - ((d[31] && d[0]) ? 1 : 0))};
      8:  return {d[0], d / 32'd2};
      9:  return {t, d * 32'd4};
      10: return {t, d * 32'd256};
      11: return {t, d * 32'd65536};
      12: return {t, d / 32'd4};
      13: return {t, d / 32'd256};
      default: return {t, d / 32'd65536};
    endcase
  endfunction

  task automatic run(input int o, input logic [31:0] d, input logic [31:0] a,
                     input logic t);
    @(negedge clk);
    op = 4'(o); data_in = d; amount_in = a; t_in = t; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] pats [6];
    logic [31:0] held;
    logic        held_t;
    string       tag;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0001;
    pats[3] = 32'h5A3C_96E1; pats[4] = $urandom(7); pats[5] = $urandom | 32'h8000_0000;

    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, result}, 33'd0);
    check("R1 reset t", {32'd0, t_out}, 33'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {out_valid, result}, 33'd0);

    // R2: latency and hold
    run(6, 32'h8000_0003, 32'd0, 1'b0);
    check("R2 valid pulse", {32'd0, out_valid}, 33'd1);
    held = result; held_t = t_out;
    data_in = 32'h1234_5678; op = 4'd3; t_in = 1'b1;
    @(negedge clk);
    check("R2 valid low", {32'd0, out_valid}, 33'd0);
    check("R2 hold", {t_out, result}, {held_t, held});

    // R3 R4 R5: full sweep of amount sign x low bits
    for (int p = 0; p < 6; p++) begin
      for (int ar = 0; ar < 2; ar++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int lo = 0; lo < 32; lo++) begin
            logic [31:0] a;
            logic        tt;
            a = {sg[0], 26'($urandom), lo[4:0]};
            tt = 1'($urandom);
            run(ar == 0 ? 0 : 1, pats[p], a, tt);
            tag = (sg == 0) ? "R3 dyn left" : (lo == 0 ? "R5 dyn neg zero" : "R4 dyn right");
            check(tag, {t_out, result}, {tt, exp_dyn(ar == 0, pats[p], a)});
          end
        end
      end
    end

    // R6 R7 R8 R9: single-bit and fixed ops
    for (int o = 2; o < 16; o++) begin
      for (int p = 0; p < 6; p++) begin
        for (int tt = 0; tt < 2; tt++) begin
          run(o, pats[p], $urandom, tt[0]);
          if (o <= 3)      tag = "R6 rotate";
          else if (o <= 5) tag = "R7 rotate thru T";
          else if (o <= 8 || o == 15) tag = "R8 one-bit shift";
          else             tag = "R9 fixed shift";
          check(tag, {t_out, result}, exp_fix(o, pats[p], tt[0]));
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule